// File: doc/BRIEF.md
# Hot-Plug System-Error Status Register

This block keeps a 24-bit status word for a six-slot hot-plug controller. It records why a system-error (SERR) request was raised. There are three kinds of cause:

- a bus arbitration time-out;
- a power fault on an individual slot;
- a change of an individual slot's switch.

Each status bit is set only when its cause is qualified by the enable, connection, redirect and mask inputs that belong to it. Software reads the word through a plain register port. It clears a bit by writing a 1 to it, under per-byte write enables.

The block drives a registered SERR request whenever any status bit is held. When a write actually clears a switch-change bit, the block emits a one-cycle release strobe for that slot. The strobe frees the slot's external interrupt pending latch, so new switch scan data can be captured. Clearing a power-fault bit frees nothing: any conventional power-fault interrupt stays with the logic that owns it.

The register port is a simple control interface with no back-pressure. A write takes effect at the clock edge where `reg_wr_en` is high. The read data always shows the current status word.

Top module: `hp_serr_stat`

## Requirements
- R1: While `rst_n` is low and right after reset, `reg_rd_data` is all zeros, `serr_req` is 0 and `sw_latch_clr` is all zeros.
- R2: Bit 23 becomes 1 on the edge after `arb_timeout_evt` is high. Writing 1 to bit 23 with `reg_wr_be[2]` set clears it.
- R3: Bit 8+i (slot A = i = 0, up to bit 13) becomes 1 only when `pf_fault_evt[i]`, `slot_connected[i]`, `pf_func_en` and `pf_serr_en` are all high in the same cycle. If any one of them is low, the bit is not set.
- R4: Bit i (slot A = i = 0, up to bit 5) becomes 1 only when `sw_change_evt[i]` and `sw_redirect[i]` are high and `sw_int_mask[i]` is low.
- R5: A write clears exactly those status bits that are written with 1 and whose byte lane is enabled. `reg_wr_be[k]` covers bits 8k+7..8k. Writing 0, or writing with the lane disabled, leaves a bit unchanged.
- R6: When a set condition and a write-1 clear hit the same bit in the same cycle, the bit ends up 1.
- R7: Bits 22:14 and 7:6 always read 0, whatever is written or signalled.
- R8: `serr_req` equals the OR of all status bits as they were one cycle earlier.
- R9: `sw_latch_clr[i]` is a one-cycle pulse in the cycle after a write that turns switch-change bit i from 1 to 0. It is 0 when that bit was already 0, or when a set won in the same cycle.
- R10: Clearing a power-fault bit raises no `sw_latch_clr` strobe and changes no other status bit.
- R11: With no qualified set and no write-1 clear, every status bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_timeout_evt | input | 1 | Pulse: arbitration time-out raised a system error |
| pf_fault_evt | input | 6 | Per-slot power-fault event pulses (slot A at bit 0) |
| slot_connected | input | 6 | Per-slot: slot is connected to bus or clock |
| pf_func_en | input | 1 | Power-fault function enable |
| pf_serr_en | input | 1 | System error on power fault enable |
| sw_change_evt | input | 6 | Per-slot switch change event pulses |
| sw_redirect | input | 6 | Per-slot switch interrupt redirect to system error |
| sw_int_mask | input | 6 | Per-slot switch interrupt mask (1 = masked) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_be | input | 3 | Byte enables for the write |
| reg_wr_data | input | 24 | Write data; 1 bits clear status |
| reg_rd_data | output | 24 | Current status word |
| serr_req | output | 1 | Registered system-error request |
| sw_latch_clr | output | 6 | Per-slot release strobe to switch interrupt pending latch |

## Verification
Directed patterns first drop one qualifier at a time for the power-fault and switch causes. This tells a fully gated set apart from one that ignores an enable, a connection bit or a mask bit. Writes of 0 and writes with disabled lanes are contrasted with true write-1 clears, which separates byte-lane decoding from the data polarity. A set and a clear on the same bit in the same cycle shows the priority, and the strobe's presence or absence tells a real clear from a no-op. Several thousand cycles of seeded random events, qualifiers and writes then mix causes across all slots against a bench-side model.

// File: rtl/hp_serr_pkg.sv
package hp_serr_pkg;
  localparam int REG_W   = 24;
  localparam int BE_W    = REG_W / 8;
  localparam int SW_LSB  = 0;   // switch-change field base
  localparam int PF_LSB  = 8;   // power-fault field base
  localparam int ARB_POS = 23;  // arbitration time-out bit

  // Expand byte enables into a per-bit write mask.
  function automatic logic [REG_W-1:0] lane_mask(input logic [BE_W-1:0] be);
    logic [REG_W-1:0] m;
    for (int b = 0; b < REG_W; b++) m[b] = be[b/8];
    return m;
  endfunction

  // Bits that hold real status for a given slot count.
  function automatic logic [REG_W-1:0] impl_mask(input int slots);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < slots; i++) begin
      m[SW_LSB+i] = 1'b1;
      m[PF_LSB+i] = 1'b1;
    end
    m[ARB_POS] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/hp_serr_cause_gate.sv
module hp_serr_cause_gate
  import hp_serr_pkg::*;
#(
  parameter int NUM_SLOTS = 6
) (
  input  logic                 arb_evt,
  input  logic [NUM_SLOTS-1:0] pf_evt,
  input  logic [NUM_SLOTS-1:0] conn,
  input  logic                 pf_func_en,
  input  logic                 pf_serr_en,
  input  logic [NUM_SLOTS-1:0] sw_evt,
  input  logic [NUM_SLOTS-1:0] sw_redir,
  input  logic [NUM_SLOTS-1:0] sw_mask,
  output logic [REG_W-1:0]     set_o
);
  logic pf_armed;
  assign pf_armed = pf_func_en & pf_serr_en;

  always_comb begin
    set_o = '0;
    set_o[ARB_POS] = arb_evt;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      set_o[PF_LSB+i] = pf_evt[i] & conn[i] & pf_armed;
      set_o[SW_LSB+i] = sw_evt[i] & sw_redir[i] & ~sw_mask[i];
    end
  end
endmodule

// File: rtl/hp_serr_w1c_cell.sv
module hp_serr_w1c_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set has priority
    else if (clr_i)  q_o <= 1'b0;
  end

  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/hp_serr_release.sv
module hp_serr_release #(
  parameter int NUM_SLOTS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] held_i,
  input  logic [NUM_SLOTS-1:0] clr_i,
  input  logic [NUM_SLOTS-1:0] set_i,
  output logic [NUM_SLOTS-1:0] strobe_o
);
  // A strobe only when a held bit is really cleared this cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) strobe_o <= '0;
    else        strobe_o <= held_i & clr_i & ~set_i;
  end

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_o != '0) |=> ((strobe_o & $past(strobe_o)) == '0));
endmodule

// File: rtl/hp_serr_req_agg.sv
module hp_serr_req_agg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  output logic         req_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) req_o <= 1'b0;
    else        req_o <= |status_i;
  end

  a_r8_req_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i != '0) |=> req_o);
  a_r8_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (status_i == '0) |=> !req_o);
endmodule

// File: rtl/hp_serr_stat.sv
module hp_serr_stat
  import hp_serr_pkg::*;
#(
  parameter int NUM_SLOTS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arb_timeout_evt,
  input  logic [NUM_SLOTS-1:0] pf_fault_evt,
  input  logic [NUM_SLOTS-1:0] slot_connected,
  input  logic                 pf_func_en,
  input  logic                 pf_serr_en,
  input  logic [NUM_SLOTS-1:0] sw_change_evt,
  input  logic [NUM_SLOTS-1:0] sw_redirect,
  input  logic [NUM_SLOTS-1:0] sw_int_mask,
  input  logic                 reg_wr_en,
  input  logic [BE_W-1:0]      reg_wr_be,
  input  logic [REG_W-1:0]     reg_wr_data,
  output logic [REG_W-1:0]     reg_rd_data,
  output logic                 serr_req,
  output logic [NUM_SLOTS-1:0] sw_latch_clr
);
  localparam logic [REG_W-1:0] IMPL = impl_mask(NUM_SLOTS);

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] wclr;
  logic [REG_W-1:0] stat_q;
  logic             unused_rsvd;

  assign wclr = reg_wr_en ? (reg_wr_data & lane_mask(reg_wr_be)) : '0;
  assign unused_rsvd = ^{wclr & ~IMPL, set_vec & ~IMPL};

  hp_serr_cause_gate #(.NUM_SLOTS(NUM_SLOTS)) u_gate (
    .arb_evt    (arb_timeout_evt),
    .pf_evt     (pf_fault_evt),
    .conn       (slot_connected),
    .pf_func_en (pf_func_en),
    .pf_serr_en (pf_serr_en),
    .sw_evt     (sw_change_evt),
    .sw_redir   (sw_redirect),
    .sw_mask    (sw_int_mask),
    .set_o      (set_vec)
  );

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (IMPL[b]) begin : g_cell
      hp_serr_w1c_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec[b]),
        .clr_i (wclr[b]),
        .q_o   (stat_q[b])
      );
    end else begin : g_rsvd
      assign stat_q[b] = 1'b0;
    end
  end

  assign reg_rd_data = stat_q;

  hp_serr_release #(.NUM_SLOTS(NUM_SLOTS)) u_release (
    .clk      (clk),
    .rst_n    (rst_n),
    .held_i   (stat_q[SW_LSB +: NUM_SLOTS]),
    .clr_i    (wclr[SW_LSB +: NUM_SLOTS]),
    .set_i    (set_vec[SW_LSB +: NUM_SLOTS]),
    .strobe_o (sw_latch_clr)
  );

  hp_serr_req_agg #(.W(REG_W)) u_agg (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (stat_q),
    .req_o    (serr_req)
  );

  // R9 / R10: a release strobe can only follow a register write
  a_r9_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_latch_clr != '0) |-> $past(reg_wr_en));
  // R10: clearing only power-fault bits never releases a switch latch
  a_r10_pf_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && (wclr[SW_LSB +: NUM_SLOTS] == '0)) |=> (sw_latch_clr == '0));
endmodule

// File: tb/hp_serr_stat_bench.sv
module hp_serr_stat_bench;
  import hp_serr_pkg::*;
  localparam int N = 6;
  localparam logic [REG_W-1:0] VALID = 24'h803F3F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arb = 0, pfen = 0, pfserr = 0, wen = 0;
  logic [N-1:0] pfe = 0, conn = 0, swe = 0, redir = 0, msk = 0;
  logic [BE_W-1:0] be = 0;
  logic [REG_W-1:0] wdat = 0;
  logic [REG_W-1:0] rd;
  logic serr;
  logic [N-1:0] strb;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [REG_W-1:0] exp_st = '0;

  always #5 clk = ~clk;

  hp_serr_stat u_hp_serr_stat (
    .clk(clk), .rst_n(rst_n), .arb_timeout_evt(arb), .pf_fault_evt(pfe),
    .slot_connected(conn), .pf_func_en(pfen), .pf_serr_en(pfserr),
    .sw_change_evt(swe), .sw_redirect(redir), .sw_int_mask(msk),
    .reg_wr_en(wen), .reg_wr_be(be), .reg_wr_data(wdat),
    .reg_rd_data(rd), .serr_req(serr), .sw_latch_clr(strb));

  function automatic logic [REG_W-1:0] bmask(input logic [BE_W-1:0] e);
    return {{8{e[2]}}, {8{e[1]}}, {8{e[0]}}};
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    arb = 0; pfe = 0; swe = 0; wen = 0; be = 0; wdat = 0;
  endtask

  // One clock: model from the requirements, then compare outputs.
  task automatic step(input string tag);
    logic [REG_W-1:0] setv, clrv, nxt;
    logic [N-1:0] es;
    logic eserr;
    setv = '0;
    setv[23] = arb;                                         // R2
    for (int i = 0; i < N; i++) begin
      setv[8+i] = pfe[i] & conn[i] & pfen & pfserr;         // R3
      setv[i]   = swe[i] & redir[i] & ~msk[i];              // R4
    end
    clrv  = wen ? (wdat & bmask(be) & VALID) : '0;          // R5, R7
    nxt   = setv | (exp_st & ~clrv);                        // R6, R11
    es    = exp_st[5:0] & clrv[5:0] & ~setv[5:0];           // R9
    eserr = |exp_st;                                        // R8
    @(posedge clk); #1;
    exp_st = nxt;
    chk(tag, "status", rd, exp_st);
    chk(tag, "serr_req", {23'd0, serr}, {23'd0, eserr});
    chk(tag, "strobe", {18'd0, strb}, {18'd0, es});
    idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "status in reset", rd, '0);
    chk("R1", "serr in reset", {23'd0, serr}, '0);
    chk("R1", "strobe in reset", {18'd0, strb}, '0);
    rst_n = 1;
    step("R1 after reset");

    // R2 arbitration bit
    arb = 1; step("R2 set");
    step("R8 serr follows");
    wen = 1; be = 3'b011; wdat = 24'h800000; step("R5 lane off keeps bit23");
    wen = 1; be = 3'b100; wdat = 24'h800000; step("R2 clear");
    step("R8 serr drops");

    // R3 power-fault gating
    conn = '1; pfen = 1; pfserr = 0; pfe = 6'b000001; step("R3 serr_en off");
    pfserr = 1; pfen = 0; pfe = 6'b000001; step("R3 func_en off");
    pfen = 1; conn = 6'b111110; pfe = 6'b000001; step("R3 disconnected");
    conn = '1; pfe = 6'b100001; step("R3 slots A and F");
    chk("R3", "pf field", rd & 24'h003F00, 24'h002100);

    // R4 switch gating
    redir = 6'b000100; msk = 6'b000100; swe = 6'b000100; step("R4 masked");
    msk = 0; redir = 0; swe = 6'b000100; step("R4 not redirected");
    redir = 6'b000100; swe = 6'b000100; step("R4 set slot C");
    chk("R4", "sw field", rd & 24'h00003F, 24'h000004);

    // R5 write 0 and lane tests
    wen = 1; be = 3'b111; wdat = 24'h000000; step("R5 write zero");
    wen = 1; be = 3'b001; wdat = 24'h003F00; step("R5 wrong lane");
    wen = 1; be = 3'b010; wdat = 24'h000100; step("R10 pf clear no strobe");
    chk("R10", "strobe after pf clear", {18'd0, strb}, '0);

    // R6 set beats clear, no strobe
    wen = 1; be = 3'b001; wdat = 24'h000004; swe = 6'b000100; step("R6 set wins");
    chk("R6", "bit2 kept", {23'd0, rd[2]}, 24'd1);
    // R9 real clear gives one pulse
    wen = 1; be = 3'b001; wdat = 24'h000004; step("R9 strobe");
    chk("R9", "strobe slot C", {18'd0, strb}, 24'h000004);
    step("R9 strobe gone");
    wen = 1; be = 3'b001; wdat = 24'h000004; step("R9 clear of zero bit");

    // R7 reserved bits
    wen = 1; be = 3'b111; wdat = 24'h7FC0C0; arb = 1; step("R7 reserved write");
    chk("R7", "reserved read", rd & ~VALID, '0);
    step("R11 hold");

    // random phase
    for (int c = 0; c < 3000; c++) begin
      arb    = ($urandom % 16) == 0;
      pfe    = 6'($urandom) & 6'($urandom);
      conn   = 6'($urandom);
      pfen   = ($urandom % 4) != 0;
      pfserr = ($urandom % 4) != 0;
      swe    = 6'($urandom) & 6'($urandom);
      redir  = 6'($urandom);
      msk    = 6'($urandom);
      wen    = ($urandom % 3) == 0;
      be     = 3'($urandom);
      wdat   = 24'($urandom);
      step("R3/R4/R5/R6/R9 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule